// File: doc/BRIEF.md
# Atomic Snoop-Bus Arbiter with Arrival-Order Queue

This block decides which of several cache nodes may place its next coherence query on a shared broadcast bus. A node signals a wish to use the bus with a one-cycle request strobe. The arbiter answers with a one-cycle grant to exactly one node at a time. It then keeps the bus closed to all other requesters until that query has been observed on the bus and a DATA reply to it has been seen. Replies may come from another cache or from memory.

The arbiter watches the bus through a monitor input: a valid flag and a two-bit operation type. Requests that cannot be served at once wait in a queue inside the block and are served in the order they arrived. When several requests land in the same cycle, the lower node index is queued ahead. The node count is a parameter with legal values 4, 8 and 16, and the queue holds one entry per node.

The controller has three states:

| State | Meaning |
|---|---|
| IDLE | No owner. |
| ISSUE | A grant has been given and the arbiter waits for the owner's query. |
| HOLD | The query has been seen and the arbiter waits for the DATA reply. |

| Transition | Condition |
|---|---|
| IDLE to ISSUE | The queue holds at least one request. |
| ISSUE to HOLD | A GETS or GETM is observed. |
| HOLD to ISSUE | DATA is observed and the queue is not empty; the head of the queue is granted at once. |
| HOLD to IDLE | DATA is observed and the queue is empty. |

Top module: `snoop_bus_arbiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `grant_o` is zero and `owner_valid_o` is low. The queue starts empty.
- R2: The monitor type is coded as follows: 2'b00 is GETS, 2'b01 is GETM, 2'b10 is DATA and 2'b11 is reserved. Once a node is granted, no other grant issues until a GETS or GETM has been observed and a DATA has been observed after it. `owner_valid_o` stays high over that whole span.
- R3: Requests that arrive in different cycles are granted in the order of their arrival, whatever their node indices.
- R4: Requests that arrive in the same cycle are queued by ascending node index, so node 0 goes first.
- R5: A request strobe from a node is ignored if that node already has a request queued or holds the bus. This includes a strobe in the cycle its DATA reply is observed.
- R6: A grant is a one-hot, one-cycle pulse. With the bus idle and the queue empty, the grant appears in the second cycle after the request strobe. From the grant cycle until the DATA cycle, `owner_o` holds the granted node's index.
- R7: If requests are waiting when the DATA that ends the current query is observed, the next grant appears in the following cycle.
- R8: Monitor traffic that does not match the current state is ignored. This covers DATA while idle, DATA before the owner's query, and the reserved type in any state.
- R9: The queue depth equals the node count, and the queue never overflows even when every node requests in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | NUM_NODES | One-cycle request strobe per node |
| mon_valid_i | input | 1 | A bus transaction is present this cycle |
| mon_type_i | input | 2 | Observed transaction type: 00 GETS, 01 GETM, 10 DATA, 11 reserved |
| grant_o | output | NUM_NODES | One-hot, one-cycle grant pulse |
| owner_valid_o | output | 1 | A node currently holds the bus |
| owner_o | output | $clog2(NUM_NODES) | Index of the node holding the bus |

## Verification
The hardest situation to reach is a request strobe that coincides with the edge at which the bus is released. This covers both a node re-requesting in its own DATA cycle and a queued node that must be granted in the very next cycle. Directed sequences place the strobe in the DATA cycle on purpose. A randomized bus agent, driven by the bench's own queue model, then sends queries, DATA replies, stray DATA and reserved types while random request strobes pile up. Many release cycles therefore meet pending requests and fresh strobes in the same cycle.

// File: rtl/snoop_arb_pkg.sv
package snoop_arb_pkg;

    typedef enum logic [1:0] {
        BUS_GETS = 2'b00,
        BUS_GETM = 2'b01,
        BUS_DATA = 2'b10,
        BUS_RSVD = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'b00,
        ARB_ISSUE = 2'b01,
        ARB_HOLD  = 2'b10
    } arb_state_e;

endpackage

// File: rtl/snoop_arb_admit.sv
// Filters request strobes: one outstanding request per node.
module snoop_arb_admit #(
    parameter int NUM_NODES = 4,
    localparam int IDW = $clog2(NUM_NODES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_NODES-1:0] req_i,
    input  logic                 release_i,
    input  logic [IDW-1:0]       release_id_i,
    output logic [NUM_NODES-1:0] accept_o
);

    logic [NUM_NODES-1:0] busy_q;
    logic [NUM_NODES-1:0] clear_w;

    assign accept_o = req_i & ~busy_q;
    assign clear_w  = release_i ? (NUM_NODES'(1) << release_id_i) : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            busy_q <= (busy_q & ~clear_w) | accept_o;
        end
    end

endmodule

// File: rtl/snoop_arb_fifo.sv
// Arrival-order queue of node indices with multi-push per cycle.
module snoop_arb_fifo #(
    parameter int NUM_NODES = 4,
    localparam int IDW  = $clog2(NUM_NODES),
    localparam int CNTW = $clog2(NUM_NODES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_NODES-1:0] push_i,
    input  logic                 pop_i,
    output logic [IDW-1:0]       head_o,
    output logic                 empty_o,
    output logic [CNTW-1:0]      fill_o
);

    logic [IDW-1:0]  slot_mem [NUM_NODES];
    logic [IDW-1:0]  head_q;
    logic [IDW-1:0]  tail_q;
    logic [CNTW-1:0] fill_q;
    logic [IDW-1:0]  slot_w [NUM_NODES];
    logic [CNTW-1:0] push_cnt_w;
    logic [CNTW-1:0] run;

    // Lower index takes the earlier slot among simultaneous arrivals.
    always_comb begin
        run = '0;
        for (int i = 0; i < NUM_NODES; i++) begin
            slot_w[i] = tail_q + run[IDW-1:0];
            if (push_i[i]) begin
                run = run + 1'b1;
            end
        end
        push_cnt_w = run;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_NODES; i++) begin
            if (push_i[i]) begin
                slot_mem[slot_w[i]] <= IDW'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            fill_q <= '0;
        end else begin
            head_q <= head_q + IDW'(pop_i);
            tail_q <= tail_q + push_cnt_w[IDW-1:0];
            fill_q <= fill_q + push_cnt_w - CNTW'(pop_i);
        end
    end

    assign head_o  = slot_mem[head_q];
    assign empty_o = (fill_q == '0);
    assign fill_o  = fill_q;

endmodule

// File: rtl/snoop_arb_fsm.sv
// IDLE -> ISSUE on waiting request; ISSUE -> HOLD on query;
// HOLD -> ISSUE / IDLE on DATA, depending on the queue.
module snoop_arb_fsm
    import snoop_arb_pkg::*;
#(
    parameter int NUM_NODES = 4,
    localparam int IDW = $clog2(NUM_NODES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 q_empty_i,
    input  logic [IDW-1:0]       q_head_i,
    input  logic                 mon_valid_i,
    input  logic [1:0]           mon_type_i,
    output logic                 pop_o,
    output logic                 release_o,
    output logic [IDW-1:0]       release_id_o,
    output logic [NUM_NODES-1:0] grant_o,
    output logic                 owner_valid_o,
    output logic [IDW-1:0]       owner_o
);

    arb_state_e state_q, state_d;
    bus_op_e    op_w;
    logic       saw_query_w;
    logic       saw_data_w;

    logic [NUM_NODES-1:0] grant_q;
    logic [IDW-1:0]       owner_q;

    assign op_w        = bus_op_e'(mon_type_i);
    assign saw_query_w = mon_valid_i && ((op_w == BUS_GETS) || (op_w == BUS_GETM));
    assign saw_data_w  = mon_valid_i && (op_w == BUS_DATA);

    always_comb begin
        state_d   = state_q;
        pop_o     = 1'b0;
        release_o = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (!q_empty_i) begin
                    pop_o   = 1'b1;
                    state_d = ARB_ISSUE;
                end
            end
            ARB_ISSUE: begin
                if (saw_query_w) begin
                    state_d = ARB_HOLD;
                end
            end
            ARB_HOLD: begin
                if (saw_data_w) begin
                    release_o = 1'b1;
                    if (!q_empty_i) begin
                        pop_o   = 1'b1;
                        state_d = ARB_ISSUE;
                    end else begin
                        state_d = ARB_IDLE;
                    end
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: grant pulse and owner index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
            owner_q <= '0;
        end else begin
            grant_q <= pop_o ? (NUM_NODES'(1) << q_head_i) : '0;
            if (pop_o) begin
                owner_q <= q_head_i;
            end
        end
    end

    assign grant_o       = grant_q;
    assign owner_o       = owner_q;
    assign owner_valid_o = (state_q != ARB_IDLE);
    assign release_id_o  = owner_q;

endmodule

// File: rtl/snoop_bus_arbiter.sv
module snoop_bus_arbiter #(
    parameter int NUM_NODES = 4,
    localparam int IDW  = $clog2(NUM_NODES),
    localparam int CNTW = $clog2(NUM_NODES + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_NODES-1:0] req_i,
    input  logic                 mon_valid_i,
    input  logic [1:0]           mon_type_i,
    output logic [NUM_NODES-1:0] grant_o,
    output logic                 owner_valid_o,
    output logic [IDW-1:0]       owner_o
);

    logic [NUM_NODES-1:0] accept_w;
    logic                 pop_w;
    logic                 release_w;
    logic [IDW-1:0]       release_id_w;
    logic [IDW-1:0]       head_w;
    logic                 empty_w;
    logic [CNTW-1:0]      fill_w;

    snoop_arb_admit #(.NUM_NODES(NUM_NODES)) admit_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .release_i    (release_w),
        .release_id_i (release_id_w),
        .accept_o     (accept_w)
    );

    snoop_arb_fifo #(.NUM_NODES(NUM_NODES)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (accept_w),
        .pop_i   (pop_w),
        .head_o  (head_w),
        .empty_o (empty_w),
        .fill_o  (fill_w)
    );

    snoop_arb_fsm #(.NUM_NODES(NUM_NODES)) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .q_empty_i     (empty_w),
        .q_head_i      (head_w),
        .mon_valid_i   (mon_valid_i),
        .mon_type_i    (mon_type_i),
        .pop_o         (pop_w),
        .release_o     (release_w),
        .release_id_o  (release_id_w),
        .grant_o       (grant_o),
        .owner_valid_o (owner_valid_o),
        .owner_o       (owner_o)
    );

endmodule

// File: rtl/snoop_bus_arbiter_chk.sv
module snoop_bus_arbiter_chk #(
    parameter int NUM_NODES = 4,
    localparam int IDW  = $clog2(NUM_NODES),
    localparam int CNTW = $clog2(NUM_NODES + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 mon_valid_i,
    input logic [1:0]           mon_type_i,
    input logic [NUM_NODES-1:0] grant_o,
    input logic                 owner_valid_o,
    input logic [IDW-1:0]       owner_o,
    input logic [CNTW-1:0]      fill_i
);

    logic data_seen;
    assign data_seen = mon_valid_i && (mon_type_i == 2'b10);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o)); // R6

    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |=> !(|grant_o)); // R6

    AST_GRANT_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> (owner_valid_o && grant_o[owner_o])); // R6

    AST_BUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_valid_o && !data_seen) |=> (!(|grant_o) && owner_valid_o && $stable(owner_o))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_valid_o && (fill_i == '0)) |=> !(|grant_o)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_i <= CNTW'(NUM_NODES)); // R9

endmodule

bind snoop_bus_arbiter snoop_bus_arbiter_chk #(.NUM_NODES(NUM_NODES)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mon_valid_i   (mon_valid_i),
    .mon_type_i    (mon_type_i),
    .grant_o       (grant_o),
    .owner_valid_o (owner_valid_o),
    .owner_o       (owner_o),
    .fill_i        (fill_w)
);

// File: tb/snoop_bus_arbiter_tb_top.sv
module snoop_bus_arbiter_tb_top;

    localparam int N   = 4;
    localparam int IDW = $clog2(N);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   req = '0;
    logic           mon_valid = 1'b0;
    logic [1:0]     mon_type = 2'b11;
    logic [N-1:0]   grant_o;
    logic           owner_valid_o;
    logic [IDW-1:0] owner_o;

    int  n_checks = 0;
    int  n_err = 0;
    bit  done = 0;

    // Reference model state: 0 idle, 1 granted, 2 query seen
    int     ms = 0;
    int     mq[$];
    bit [N-1:0] mpend = '0;
    int     mowner = 0;
    bit [N-1:0] mgrant = '0;

    always #5 clk = ~clk;

    snoop_bus_arbiter #(.NUM_NODES(N)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_i         (req),
        .mon_valid_i   (mon_valid),
        .mon_type_i    (mon_type),
        .grant_o       (grant_o),
        .owner_valid_o (owner_valid_o),
        .owner_o       (owner_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    endtask

    // Model built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mq.delete(); mpend = '0; mowner = 0; mgrant = '0;
        end else begin
            bit [N-1:0] acc;
            bit [N-1:0] ng;
            bit is_q, is_d;
            acc  = req & ~mpend;
            ng   = '0;
            is_q = mon_valid && (mon_type == 2'b00 || mon_type == 2'b01);
            is_d = mon_valid && (mon_type == 2'b10);
            case (ms)
                0: if (mq.size() > 0) begin
                       mowner = mq.pop_front(); ng[mowner] = 1'b1; ms = 1;
                   end
                1: if (is_q) ms = 2;
                default: if (is_d) begin
                       mpend[mowner] = 1'b0;
                       if (mq.size() > 0) begin
                           mowner = mq.pop_front(); ng[mowner] = 1'b1; ms = 1;
                       end else begin
                           ms = 0;
                       end
                   end
            endcase
            for (int i = 0; i < N; i++) begin
                if (acc[i]) begin
                    mq.push_back(i);
                    mpend[i] = 1'b1;
                end
            end
            mgrant = ng;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(grant_o == mgrant, "R3/R4/R6 grant vs model", int'(grant_o), int'(mgrant));
            check(owner_valid_o == (ms != 0), "R2 owner_valid vs model", int'(owner_valid_o), int'(ms != 0));
            if (ms != 0)
                check(int'(owner_o) == mowner, "R6 owner vs model", int'(owner_o), mowner);
        end
    end

    // Serve one granted node: query, gap, DATA (optionally with re-request)
    task automatic serve(input int exp, input string tag, input bit rereq);
        for (int w = 0; w < 40 && grant_o == '0; w++) @(negedge clk);
        check(grant_o == (N'(1) << exp), tag, int'(grant_o), 1 << exp);
        mon_valid = 1'b1; mon_type = 2'b01;
        @(negedge clk);
        mon_valid = 1'b0;
        @(negedge clk);
        mon_valid = 1'b1; mon_type = 2'b10;
        if (rereq) req[exp] = 1'b1;
        @(negedge clk);
        mon_valid = 1'b0; req = '0;
    endtask

    initial begin
        #(10 * 200000);
        n_checks++; n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: outputs quiet while in reset
        check(grant_o == '0, "R1 grant in reset", int'(grant_o), 0);
        check(owner_valid_o == 1'b0, "R1 owner_valid in reset", int'(owner_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(grant_o == '0, "R1 grant after reset", int'(grant_o), 0);
        check(owner_valid_o == 1'b0, "R1 owner_valid after reset", int'(owner_valid_o), 0);

        // R4 / R9: every node in the same cycle, full queue
        req = '1;
        @(negedge clk);
        req = '0;
        serve(0, "R4 simultaneous node0", 0);
        check(grant_o == 4'b0010, "R7 next grant right after DATA", int'(grant_o), 2);
        serve(1, "R4 simultaneous node1", 0);
        serve(2, "R4 simultaneous node2", 0);
        serve(3, "R9 simultaneous node3 from full queue", 0);

        // R3 / R5 / R6: arrival order beats index, duplicates dropped
        repeat (3) @(negedge clk);
        req = 4'b1000;
        @(negedge clk);
        check(grant_o == '0, "R6 no grant one cycle after strobe", int'(grant_o), 0);
        req = 4'b0001;
        @(negedge clk);
        req = 4'b1000;      // node3 again while holding the bus
        serve(3, "R3 earlier arrival node3 first", 0);
        serve(0, "R3 later arrival node0 second", 1);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            check(grant_o == '0, "R5 repeated strobes ignored", int'(grant_o), 0);
        end
        check(owner_valid_o == 1'b0, "R5 bus idle after duplicates", int'(owner_valid_o), 0);

        // R8: stray DATA while idle, DATA before query, reserved type
        mon_valid = 1'b1; mon_type = 2'b10;
        @(negedge clk);
        mon_valid = 1'b0;
        repeat (2) @(negedge clk);
        check(owner_valid_o == 1'b0 && grant_o == '0, "R8 idle DATA no effect", int'(owner_valid_o), 0);
        req = 4'b0010;
        @(negedge clk);
        req = '0;
        @(negedge clk);
        check(grant_o == 4'b0010, "R6 grant two cycles after strobe", int'(grant_o), 2);
        mon_valid = 1'b1; mon_type = 2'b10;   // DATA before the query
        @(negedge clk);
        mon_valid = 1'b0; req = 4'b0100;
        @(negedge clk);
        req = '0;
        check(owner_valid_o == 1'b1 && owner_o == 2'd1, "R8 early DATA keeps owner", int'(owner_o), 1);
        mon_valid = 1'b1; mon_type = 2'b11;   // reserved
        @(negedge clk);
        mon_valid = 1'b1; mon_type = 2'b10;   // still no query: ignored
        @(negedge clk);
        mon_valid = 1'b0;
        @(negedge clk);
        check(grant_o == '0 && owner_o == 2'd1, "R8 reserved and early DATA ignored", int'(grant_o), 0);
        mon_valid = 1'b1; mon_type = 2'b00;   // GETS
        @(negedge clk);
        mon_valid = 1'b1; mon_type = 2'b11;
        @(negedge clk);
        check(grant_o == '0 && owner_valid_o, "R2 bus held after query", int'(grant_o), 0);
        mon_valid = 1'b1; mon_type = 2'b10;
        @(negedge clk);
        mon_valid = 1'b0;
        check(grant_o == 4'b0100, "R7 waiting node granted after DATA", int'(grant_o), 4);
        serve(2, "R8 node2 served", 0);

        // Constrained random phase, compared against the model every cycle
        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) req[i] = (c < 5600) && ($urandom % 7 == 0);
            mon_valid = 1'b0; mon_type = 2'b11;
            case (ms)
                1: begin
                    int r;
                    r = $urandom % 10;
                    if (r < 4) begin mon_valid = 1'b1; mon_type = 2'($urandom % 2); end
                    else if (r == 4) begin mon_valid = 1'b1; mon_type = 2'b10; end
                    else if (r == 5) begin mon_valid = 1'b1; mon_type = 2'b11; end
                end
                2: begin
                    int r;
                    r = $urandom % 8;
                    if (r < 3) begin mon_valid = 1'b1; mon_type = 2'b10; end
                    else if (r == 3) begin mon_valid = 1'b1; mon_type = 2'b11; end
                end
                default: if ($urandom % 6 == 0) begin mon_valid = 1'b1; mon_type = 2'b10; end
            endcase
        end
        @(negedge clk);
        req = '0; mon_valid = 1'b0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule